// File: doc/BRIEF.md
# Ping-Pong DMA Channel

This block is one DMA channel that shuttles data between a fixed peripheral FIFO address and two memory buffers, which it serves alternately. Software sets up the channel over a small word-addressed register bus. It loads a peripheral address and, for each buffer, a start address and a transfer count. It then raises the run bit and the buffer enable bits. Every transfer unit waits for the peripheral request line and makes two single-beat accesses on a valid/ready data bus: a read from the source, then a write of the same word to the destination.

When a buffer's live count reaches zero, the channel drops that buffer's enable, raises its done flag and, if the other buffer is enabled, moves on to it. This lets software refill one buffer while the other streams. The done interrupt is the OR of the two done flags. To stop the channel, software clears the run bit and polls the halt flag. That flag rises only after any unit already on the bus has finished.

Top module: `pingpong_dma_chan`

## Requirements
- R1: After reset the mode word (offset 0x00) reads 0x00000040 (only halt set), the done interrupt is low, no bus request is valid and the remaining byte count is 0.
- R2: A write to 0x00 sets, and a write to 0x04 clears, each configuration bit written as 1. Bits written as 0 are left unchanged. The configuration bits are: width code at bits 8:7 (0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes per unit), size flag bit 11, direction bit 12, endian bit 13, device ID bits 19:16 and device address-high bits 23:20. All of them read back at the same positions. Offset 0x04 reads as 0.
- R3: Halt (bit 6), active buffer (bit 4) and the done flags (bit 1 for buffer 0, bit 3 for buffer 1) are not changed by writes to 0x00. Bits 0 (enable 0), 2 (enable 1) and 5 (run) can be set and cleared, and enable 0 and enable 1 can be set in one write.
- R4: Offsets 0x08 (peripheral address), 0x0C/0x14 (start of buffer 0/1) hold 32 bits. Offsets 0x10/0x18 (buffer 0/1 count) hold a 16-bit count in bits 15:0 and a 4-bit address-high field in bits 19:16, and return 0 in every other bit.
- R5: With direction 0, each unit reads the peripheral address and then writes the data to memory. With direction 1, it reads memory and then writes the peripheral address. No unit starts while the peripheral request is low, and valid, address and write-enable are held until ready.
- R6: The memory address of a unit is the buffer start plus the number of units already done in that buffer times the width in bytes.
- R7: Each finished unit decrements the active buffer's count register. At zero, the buffer's done flag is set and its enable is cleared.
- R8: After a buffer completes, the channel serves the other buffer if that one is enabled, and the active-buffer bit shows which buffer is in use.
- R9: With run set and no buffer enabled, the channel issues nothing and halt stays 0. Enabling either buffer later starts it, switching the active buffer if needed.
- R10: Writing 1 to a done bit at 0x04 clears it. The done interrupt is high exactly while either done flag is set.
- R11: Clearing run lets a unit already on the bus finish, including its write. No further unit starts, and halt reads 1 once the channel is idle. Setting run again resumes the same buffer where it stopped.
- R12: A buffer enabled with a count of 0 completes at once with no bus traffic. Its done flag is set and its enable cleared.
- R13: The remaining-bytes output equals the active buffer's count times the width in bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data for the offset presented in the previous cycle |
| periph_req | input | 1 | Peripheral ready for a unit |
| bus_valid | output | 1 | Data-side request valid |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | 32 | Request address |
| bus_wdata | output | 32 | Write data |
| bus_ready | input | 1 | Request accepted this cycle |
| bus_rdata | input | 32 | Read data, valid with ready on a read |
| done_irq | output | 1 | OR of the two done flags |
| remaining_bytes | output | 18 | Bytes left in the active buffer |

## Verification
A stale unit offset shows up directly as a wrong memory address on the very next unit. A count that misses a decrement shows up as an extra bus write and a late done flag one unit later. A wrong active-buffer bit makes the second buffer's data appear at the start of the write stream, so checking the order of logged writes catches it within the first unit. A halt flag that rises too early or too late shows in the mode word read right after the run bit is cleared, and a unit lost or duplicated across a stop and resume shows in the count of logged writes.

// File: rtl/ppdma_pkg.sv
package ppdma_pkg;
  localparam int unsigned REG_W = 32;

  // register byte offsets
  localparam logic [4:0] OFS_MSET = 5'h00;
  localparam logic [4:0] OFS_MCLR = 5'h04;
  localparam logic [4:0] OFS_PER  = 5'h08;
  localparam logic [4:0] OFS_S0   = 5'h0C;
  localparam logic [4:0] OFS_C0   = 5'h10;
  localparam logic [4:0] OFS_S1   = 5'h14;
  localparam logic [4:0] OFS_C1   = 5'h18;

  // mode word bit positions
  localparam int unsigned BIT_EN0  = 0;
  localparam int unsigned BIT_DN0  = 1;
  localparam int unsigned BIT_EN1  = 2;
  localparam int unsigned BIT_DN1  = 3;
  localparam int unsigned BIT_AB   = 4;
  localparam int unsigned BIT_RUN  = 5;
  localparam int unsigned BIT_HALT = 6;
  localparam int unsigned WID_LSB  = 7;
  localparam int unsigned BIT_DIR  = 12;

  // stored-only configuration bits: width, size, dir, endian, id, addr-high
  localparam logic [REG_W-1:0] CFG_MASK = 32'h00FF_3980;

  typedef enum logic [1:0] {ENG_IDLE, ENG_RD, ENG_WR} eng_state_t;

  function automatic logic [1:0] width_shift(input logic [1:0] code);
    case (code)
      2'd0:    width_shift = 2'd0;
      2'd1:    width_shift = 2'd1;
      default: width_shift = 2'd2;
    endcase
  endfunction
endpackage

// File: rtl/ppdma_regs.sv
module ppdma_regs
  import ppdma_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned HI_W   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [4:0]        reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              eng_idle,
  input  logic              unit_done,
  input  logic              halt_in,
  output logic              run,
  output logic              dir,
  output logic              act_ready,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [ADDR_W-1:0] periph_addr,
  output logic              done_irq,
  output logic [CNT_W+1:0]  remaining
);
  logic [REG_W-1:0]  cfg_q, cfg_n;
  logic [1:0]        en_q, en_n, dn_q, dn_n;
  logic              run_q, run_n, ab_q, ab_n;
  logic [CNT_W-1:0]  ofs_q, ofs_n;
  logic [ADDR_W-1:0] per_q, per_n;
  logic [ADDR_W-1:0] start_q [2];
  logic [ADDR_W-1:0] start_n [2];
  logic [CNT_W-1:0]  cnt_q [2];
  logic [CNT_W-1:0]  cnt_n [2];
  logic [HI_W-1:0]   hi_q [2];
  logic [HI_W-1:0]   hi_n [2];
  logic [1:0]        shift;
  logic [REG_W-1:0]  mode_word, rd_n;

  assign shift = width_shift(cfg_q[WID_LSB +: 2]);

  always_comb begin
    cfg_n = cfg_q; en_n = en_q; dn_n = dn_q; run_n = run_q;
    ab_n = ab_q; ofs_n = ofs_q; per_n = per_q;
    for (int b = 0; b < 2; b++) begin
      start_n[b] = start_q[b]; cnt_n[b] = cnt_q[b]; hi_n[b] = hi_q[b];
    end
    // channel progress
    if (unit_done) begin
      cnt_n[ab_q] = cnt_q[ab_q] - 1'b1;
      ofs_n = ofs_q + 1'b1;
      if (cnt_q[ab_q] == CNT_W'(1)) begin
        dn_n[ab_q] = 1'b1; en_n[ab_q] = 1'b0; ofs_n = '0;
      end
    end else if (eng_idle && en_q[ab_q] && cnt_q[ab_q] == '0) begin
      dn_n[ab_q] = 1'b1; en_n[ab_q] = 1'b0; ofs_n = '0;
    end else if (eng_idle && !en_q[ab_q] && en_q[~ab_q]) begin
      ab_n = ~ab_q; ofs_n = '0;
    end
    // software access, applied on top of progress
    if (reg_we) begin
      case (reg_addr)
        OFS_MSET: begin
          cfg_n = cfg_n | (reg_wdata & CFG_MASK);
          en_n[0] = en_n[0] | reg_wdata[BIT_EN0];
          en_n[1] = en_n[1] | reg_wdata[BIT_EN1];
          run_n = run_n | reg_wdata[BIT_RUN];
        end
        OFS_MCLR: begin
          cfg_n = cfg_n & ~(reg_wdata & CFG_MASK);
          en_n[0] = en_n[0] & ~reg_wdata[BIT_EN0];
          en_n[1] = en_n[1] & ~reg_wdata[BIT_EN1];
          dn_n[0] = dn_n[0] & ~reg_wdata[BIT_DN0];
          dn_n[1] = dn_n[1] & ~reg_wdata[BIT_DN1];
          run_n = run_n & ~reg_wdata[BIT_RUN];
        end
        OFS_PER: per_n = reg_wdata[ADDR_W-1:0];
        OFS_S0:  start_n[0] = reg_wdata[ADDR_W-1:0];
        OFS_S1:  start_n[1] = reg_wdata[ADDR_W-1:0];
        OFS_C0: begin
          cnt_n[0] = reg_wdata[CNT_W-1:0]; hi_n[0] = reg_wdata[CNT_W +: HI_W];
        end
        OFS_C1: begin
          cnt_n[1] = reg_wdata[CNT_W-1:0]; hi_n[1] = reg_wdata[CNT_W +: HI_W];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    mode_word = cfg_q;
    mode_word[BIT_EN0]  = en_q[0];
    mode_word[BIT_DN0]  = dn_q[0];
    mode_word[BIT_EN1]  = en_q[1];
    mode_word[BIT_DN1]  = dn_q[1];
    mode_word[BIT_AB]   = ab_q;
    mode_word[BIT_RUN]  = run_q;
    mode_word[BIT_HALT] = halt_in;
    case (reg_addr)
      OFS_MSET: rd_n = mode_word;
      OFS_PER:  rd_n = REG_W'(per_q);
      OFS_S0:   rd_n = REG_W'(start_q[0]);
      OFS_S1:   rd_n = REG_W'(start_q[1]);
      OFS_C0:   rd_n = REG_W'({hi_q[0], cnt_q[0]});
      OFS_C1:   rd_n = REG_W'({hi_q[1], cnt_q[1]});
      default:  rd_n = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0; en_q <= '0; dn_q <= '0; run_q <= 1'b0; ab_q <= 1'b0;
      ofs_q <= '0; per_q <= '0; reg_rdata <= '0;
      for (int b = 0; b < 2; b++) begin
        start_q[b] <= '0; cnt_q[b] <= '0; hi_q[b] <= '0;
      end
    end else begin
      cfg_q <= cfg_n; en_q <= en_n; dn_q <= dn_n; run_q <= run_n; ab_q <= ab_n;
      ofs_q <= ofs_n; per_q <= per_n; reg_rdata <= rd_n;
      for (int b = 0; b < 2; b++) begin
        start_q[b] <= start_n[b]; cnt_q[b] <= cnt_n[b]; hi_q[b] <= hi_n[b];
      end
    end
  end

  assign run         = run_q;
  assign dir         = cfg_q[BIT_DIR];
  assign act_ready   = en_q[ab_q] && (cnt_q[ab_q] != '0);
  assign mem_addr    = start_q[ab_q] + (ADDR_W'(ofs_q) << shift);
  assign periph_addr = per_q;
  assign done_irq    = dn_q[0] | dn_q[1];
  assign remaining   = {2'b00, cnt_q[ab_q]} << shift;
endmodule

// File: rtl/ppdma_engine.sv
module ppdma_engine
  import ppdma_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              dir,
  input  logic              act_ready,
  input  logic              periph_req,
  input  logic [ADDR_W-1:0] mem_addr,
  input  logic [ADDR_W-1:0] periph_addr,
  output logic              bus_valid,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_ready,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              eng_idle,
  output logic              unit_done,
  output logic              halted
);
  eng_state_t        state_q;
  logic [ADDR_W-1:0] dst_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ENG_IDLE; dst_q <= '0; bus_valid <= 1'b0; bus_we <= 1'b0;
      bus_addr <= '0; bus_wdata <= '0; halted <= 1'b1;
    end else begin
      halted <= !run && (state_q == ENG_IDLE);
      case (state_q)
        ENG_IDLE: if (run && act_ready && periph_req) begin
          bus_valid <= 1'b1;
          bus_we    <= 1'b0;
          bus_addr  <= dir ? mem_addr : periph_addr;
          dst_q     <= dir ? periph_addr : mem_addr;
          state_q   <= ENG_RD;
        end
        ENG_RD: if (bus_ready) begin
          bus_we    <= 1'b1;
          bus_addr  <= dst_q;
          bus_wdata <= bus_rdata;
          state_q   <= ENG_WR;
        end
        default: if (bus_ready) begin
          bus_valid <= 1'b0;
          bus_we    <= 1'b0;
          state_q   <= ENG_IDLE;
        end
      endcase
    end
  end

  assign eng_idle  = (state_q == ENG_IDLE);
  assign unit_done = (state_q == ENG_WR) && bus_ready;
endmodule

// File: rtl/pingpong_dma_chan.sv
module pingpong_dma_chan
  import ppdma_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned HI_W   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [4:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              periph_req,
  output logic              bus_valid,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_ready,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              done_irq,
  output logic [CNT_W+1:0]  remaining_bytes
);
  logic              go_w, dir_w, act_ready_w, eng_idle_w, unit_done_w, halt_w;
  logic [ADDR_W-1:0] mem_addr_w, per_addr_w;

  ppdma_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .HI_W(HI_W)) regs_i (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .eng_idle(eng_idle_w),
    .unit_done(unit_done_w), .halt_in(halt_w), .run(go_w), .dir(dir_w),
    .act_ready(act_ready_w), .mem_addr(mem_addr_w), .periph_addr(per_addr_w),
    .done_irq(done_irq), .remaining(remaining_bytes)
  );

  ppdma_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) eng_i (
    .clk(clk), .rst(rst), .run(go_w), .dir(dir_w), .act_ready(act_ready_w),
    .periph_req(periph_req), .mem_addr(mem_addr_w), .periph_addr(per_addr_w),
    .bus_valid(bus_valid), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_ready(bus_ready), .bus_rdata(bus_rdata),
    .eng_idle(eng_idle_w), .unit_done(unit_done_w), .halted(halt_w)
  );
endmodule

// File: rtl/ppdma_chk.sv
module ppdma_chk #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              periph_req,
  input logic              bus_valid,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              bus_ready,
  input logic              go_w,
  input logic              halt_w
);
  // R5: request fields held while waiting for ready
  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    bus_valid && !bus_ready |=> bus_valid && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata));

  // R5: an accepted read is followed by the write of the same unit
  p_rd_then_wr_r5: assert property (@(posedge clk) disable iff (rst)
    bus_valid && !bus_we && bus_ready |=> bus_valid && bus_we);

  // R5: a unit begins only after the peripheral asked for it
  p_start_req_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_valid) |-> $past(periph_req));

  // R11: a halted channel has nothing on the bus
  p_halt_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    halt_w |-> !bus_valid);

  // R11: a running channel does not report halt
  p_run_not_halted_r11: assert property (@(posedge clk) disable iff (rst)
    go_w |=> !halt_w);
endmodule

bind pingpong_dma_chan ppdma_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst(rst), .periph_req(periph_req), .bus_valid(bus_valid),
  .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_ready(bus_ready), .go_w(go_w), .halt_w(halt_w)
);

// File: tb/pingpong_dma_chan_tb_top.sv
module pingpong_dma_chan_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        periph_req = 1'b1;
  logic        bus_valid, bus_we;
  logic [31:0] bus_addr, bus_wdata;
  logic        bus_ready;
  logic [31:0] bus_rdata;
  logic        done_irq;
  logic [17:0] remaining_bytes;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  int log_n = 0;
  logic [31:0] log_addr [64];
  logic [31:0] log_data [64];

  always #2.5 clk = ~clk;

  pingpong_dma_chan dut_i (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .periph_req(periph_req),
    .bus_valid(bus_valid), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_ready(bus_ready), .bus_rdata(bus_rdata),
    .done_irq(done_irq), .remaining_bytes(remaining_bytes)
  );

  function automatic logic [31:0] rfun(input logic [31:0] a);
    return a ^ 32'hA5A5_5A5A;
  endfunction

  // memory / peripheral responder: ready one cycle after valid, log writes
  always @(negedge clk) begin
    if (rst) begin
      bus_ready = 1'b0;
      bus_rdata = '0;
    end else if (bus_ready) begin
      bus_ready = 1'b0;
    end else if (bus_valid) begin
      bus_ready = 1'b1;
      bus_rdata = rfun(bus_addr);
      if (bus_we && log_n < 64) begin
        log_addr[log_n] = bus_addr;
        log_data[log_n] = bus_wdata;
        log_n++;
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_log(input int target);
    for (int i = 0; i < 2000 && log_n < target; i++) @(negedge clk);
    idle(6);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(5'h00, v);
    check("R1 mode after reset", v, 32'h0000_0040);
    check("R1 irq after reset", 32'(done_irq), 32'd0);
    check("R1 valid after reset", 32'(bus_valid), 32'd0);
    check("R1 remaining after reset", 32'(remaining_bytes), 32'd0);
  endtask

  task automatic t_mode_bits();
    logic [31:0] v;
    wr(5'h00, 32'h0023_395A);
    rd(5'h00, v);
    check("R2/R3 set stored bits, status ignored", v, 32'h0023_3940);
    wr(5'h04, 32'h0020_1100);
    rd(5'h00, v);
    check("R2 clear selected bits", v, 32'h0003_2840);
    rd(5'h04, v);
    check("R2 clear offset reads zero", v, 32'h0);
    wr(5'h04, 32'hFFFF_FFFF);
    rd(5'h00, v);
    check("R2 clear all", v, 32'h0000_0040);
  endtask

  task automatic t_regs();
    logic [31:0] v;
    wr(5'h10, 32'hFFFF_FFFF);
    rd(5'h10, v);
    check("R4 count field mask", v, 32'h000F_FFFF);
    wr(5'h0C, 32'h1234_5678);
    rd(5'h0C, v);
    check("R4 start0", v, 32'h1234_5678);
    wr(5'h08, 32'hCAFE_BABE);
    rd(5'h08, v);
    check("R4 peripheral address", v, 32'hCAFE_BABE);
    idle(1);
    check("R13 bytes width code 0", 32'(remaining_bytes), 32'h0_FFFF);
    wr(5'h00, 32'h80);
    idle(1);
    check("R13 bytes width code 1", 32'(remaining_bytes), 32'h1_FFFE);
    wr(5'h04, 32'h80);
    wr(5'h00, 32'h100);
    idle(1);
    check("R13 bytes width code 2", 32'(remaining_bytes), 32'h3_FFFC);
    wr(5'h04, 32'h180);
  endtask

  task automatic t_dev_to_mem();
    logic [31:0] v;
    int base;
    base = log_n;
    wr(5'h08, 32'h4000_0000);
    wr(5'h0C, 32'h0000_1000);
    wr(5'h10, 32'd3);
    wr(5'h00, 32'h121);
    wait_log(base + 3);
    check("R7 three units written", 32'(log_n - base), 32'd3);
    for (int i = 0; i < 3; i++) begin
      check("R6 memory address step", log_addr[base+i], 32'h1000 + 32'(4*i));
      check("R5 data from peripheral", log_data[base+i], rfun(32'h4000_0000));
    end
    rd(5'h00, v);
    check("R7/R11 done0 set, enable0 cleared, running", v, 32'h0000_0122);
    rd(5'h10, v);
    check("R7 count reached zero", v, 32'h0);
    check("R10 irq with done", 32'(done_irq), 32'd1);
    wr(5'h04, 32'h2);
    rd(5'h00, v);
    check("R10 done0 cleared", v, 32'h0000_0120);
    check("R10 irq dropped", 32'(done_irq), 32'd0);
  endtask

  task automatic t_pingpong();
    logic [31:0] v;
    int base;
    base = log_n;
    wr(5'h0C, 32'h2000); wr(5'h10, 32'd2);
    wr(5'h14, 32'h3000); wr(5'h18, 32'd2);
    wr(5'h08, 32'h5000_0000);
    wr(5'h04, 32'h100);
    wr(5'h00, 32'h1080);
    wr(5'h00, 32'h05);
    wait_log(base + 4);
    check("R8 four units", 32'(log_n - base), 32'd4);
    check("R8 order 0", log_data[base+0], rfun(32'h2000));
    check("R8 order 1", log_data[base+1], rfun(32'h2002));
    check("R8 order 2", log_data[base+2], rfun(32'h3000));
    check("R8 order 3", log_data[base+3], rfun(32'h3002));
    check("R5 write to peripheral", log_addr[base+3], 32'h5000_0000);
    rd(5'h00, v);
    check("R8 both done, active buffer 1", v, 32'h0000_10BA);
  endtask

  task automatic t_idle_wait();
    logic [31:0] v;
    int base;
    wr(5'h04, 32'h0A);
    wr(5'h14, 32'h3100); wr(5'h18, 32'd1);
    base = log_n;
    idle(20);
    check("R9 no traffic with nothing enabled", 32'(log_n - base), 32'd0);
    rd(5'h00, v);
    check("R9 idle but not halted", v, 32'h0000_10B0);
    wr(5'h00, 32'h04);
    wait_log(base + 1);
    check("R9 buffer1 resumed", log_data[base], rfun(32'h3100));
    wr(5'h0C, 32'h2100); wr(5'h10, 32'd1);
    wr(5'h00, 32'h01);
    wait_log(base + 2);
    check("R9 switch back to buffer0", log_data[base+1], rfun(32'h2100));
    rd(5'h00, v);
    check("R9 active buffer 0, both done", v, 32'h0000_10AA);
    wr(5'h04, 32'h0A);
  endtask

  task automatic t_req_gate();
    int base;
    base = log_n;
    periph_req = 1'b0;
    wr(5'h0C, 32'h2200); wr(5'h10, 32'd1);
    wr(5'h00, 32'h01);
    idle(20);
    check("R5 held off without request", 32'(log_n - base), 32'd0);
    check("R5 no valid without request", 32'(bus_valid), 32'd0);
    periph_req = 1'b1;
    wait_log(base + 1);
    check("R5 unit after request", log_data[base], rfun(32'h2200));
    wr(5'h04, 32'h02);
  endtask

  task automatic t_zero_count();
    logic [31:0] v;
    int base;
    base = log_n;
    wr(5'h18, 32'd0);
    wr(5'h00, 32'h04);
    idle(10);
    check("R12 no traffic for zero count", 32'(log_n - base), 32'd0);
    rd(5'h00, v);
    check("R12 done1 set, enable1 cleared", v, 32'h0000_10B8);
    wr(5'h04, 32'h08);
  endtask

  task automatic t_halt();
    logic [31:0] v;
    int base;
    base = log_n;
    wr(5'h0C, 32'h2400); wr(5'h10, 32'd5);
    wr(5'h00, 32'h01);
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (bus_valid && !bus_we) break;
    end
    wr(5'h04, 32'h20);
    idle(20);
    check("R11 in-flight unit completes", 32'(log_n - base), 32'd1);
    check("R11 bus quiet after stop", 32'(bus_valid), 32'd0);
    rd(5'h00, v);
    check("R11 halted with enable kept", v, 32'h0000_10C1);
    rd(5'h10, v);
    check("R11 count after stop", v, 32'd4);
    check("R13 remaining bytes 16-bit", 32'(remaining_bytes), 32'd8);
    wr(5'h00, 32'h20);
    wait_log(base + 5);
    check("R11 resume finishes buffer", 32'(log_n - base), 32'd5);
    check("R6/R11 resume continues offset", log_data[base+4], rfun(32'h2408));
    rd(5'h00, v);
    check("R11 running after resume", v, 32'h0000_10A2);
  endtask

  initial begin
    idle(4);
    rst = 1'b0;
    t_reset();
    t_mode_bits();
    t_regs();
    t_dev_to_mem();
    t_pingpong();
    t_idle_wait();
    t_req_gate();
    t_zero_count();
    t_halt();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cycles, 100000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule